// File: doc/BRIEF.md
# Scratchpad Frame Readiness Tracker

This block lets a core know when words prefetched into its local scratchpad have landed, without a valid bit per word. A region at the bottom of the scratchpad is split into a configured number of equal frames, used in circular order. Each frame keeps one counter of the words that have arrived in it. The core asks to start on the current (head) frame with a word count. It is stalled until that many words are in. When the core is done with the frame, it hands words back with release requests. Once the released words add up to the frame size, the frame is cleared and the head moves on.

The prefetch side watches a per-frame free flag to see where it may write. An arrival into a full frame, or beyond the last frame, is refused and flagged as an overflow. A release takes one cycle to commit. Because the count a start depends on may still change, a start cannot finish while a release is being requested or is pending.

Top module: `spad_frame_tracker`

## Requirements
- R1: After reset the block holds 4 frames of 16 words, the head is frame 0, frame_free is 8'h0F, arr_overflow is 0 and stall is 0 while start_req is low.
- R2: A configuration word with the frame count in bits [3:0] and the frame size in words in bits [26:16] is loaded when cfg_we is high. If valid, it clears every counter, the head, the release accumulator and any pending release.
- R3: A configuration write is ignored if the count is 0 or above 8, the size is 0, count × size exceeds 1024 words, or any other bit is set.
- R4: An arrival at word offset off counts into frame off / size. An offset at or above count × size is not counted and raises the overflow flag.
- R5: While start_req is high, stall is high in the same cycle whenever the head frame holds fewer words than start_words. It falls in the cycle after the arrival pulse of the last needed word.
- R6: Release words accumulate for the head frame and commit one cycle after the request. When the accumulated total reaches the frame size, the head frame's counter clears and the head moves to the next frame, wrapping to 0 after the last.
- R7: A start is stalled in the cycle of a release request and in the following cycle, whatever the word counts.
- R8: frame_free[i] is 1 exactly when i is below the frame count and frame i holds fewer words than the frame size.
- R9: An arrival into a full frame leaves its counter unchanged and raises arr_overflow for exactly one cycle, the cycle after the arrival.
- R10: A start for 0 words does not stall when no release is requested or pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 32 | Configuration word (count [3:0], size [26:16]) |
| arr_valid | input | 1 | One prefetched word arrived this cycle |
| arr_offset | input | 10 | Word offset of the arrival in the scratchpad |
| start_req | input | 1 | Core waits to start the head frame |
| start_words | input | 11 | Words the start needs in the head frame |
| rel_req | input | 1 | Core releases words of the head frame |
| rel_words | input | 11 | Number of words released |
| stall | output | 1 | Core must hold its start request |
| frame_free | output | 8 | Per-frame flag: frame may accept data |
| arr_overflow | output | 1 | Last-cycle arrival was refused |
| head_idx | output | 3 | Current head frame |

## Verification
The embedded properties watch, on every cycle, the behaviours that hold at all times. Counters never pass the frame size. The located frame is unique. The head stays inside the configured count and moves on each commit. A configuration load returns the head to zero. No free flag is raised above the frame count. An overflow pulse always follows an arrival. A start never completes in the cycle after a release request.

Only the directed scenarios can show the values that depend on the whole history:

- the exact cycle when a stall falls after the final arrival;
- partial releases adding up before a commit;
- the head wrapping;
- the field positions and the legality checks in the configuration word;
- the offset-to-frame mapping under a non-default frame size.

// File: rtl/spad_frame_pkg.sv
`timescale 1ns/1ps
// Shared constants for the frame tracker: layout of the configuration word.
// Assumes field widths are supplied by the modules that use these positions.
package spad_frame_pkg;
    localparam int CFG_W        = 32;
    localparam int CFG_CNT_LSB  = 0;
    localparam int CFG_SIZE_LSB = 16;
endpackage

// File: rtl/spad_frame_cfg.sv
`timescale 1ns/1ps
// Configuration register: decodes the frame count and frame size fields,
// rejects illegal words, and emits a load pulse that resets tracking state.
// Assumes SPAD_WORDS fits in SIZE_W bits and MAX_FRAMES in FCNT_W bits.
module spad_frame_cfg
    import spad_frame_pkg::*;
#(
    parameter int MAX_FRAMES = 8,
    parameter int SPAD_WORDS = 1024,
    parameter int DEF_FRAMES = 4,
    parameter int DEF_SIZE   = 16,
    localparam int FCNT_W    = $clog2(MAX_FRAMES + 1),
    localparam int SIZE_W    = $clog2(SPAD_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_word,
    output logic              cfg_load,
    output logic [FCNT_W-1:0] num_frames,
    output logic [SIZE_W-1:0] frame_size
);
    localparam int PROD_W = FCNT_W + SIZE_W;
    localparam logic [CFG_W-1:0] FIELD_MASK =
        (CFG_W'((1 << FCNT_W) - 1) << CFG_CNT_LSB) |
        (CFG_W'((1 << SIZE_W) - 1) << CFG_SIZE_LSB);

    logic [FCNT_W-1:0] cnt_f;
    logic [SIZE_W-1:0] size_f;
    logic [PROD_W-1:0] span;
    logic              legal;

    // Field extraction and legality of an incoming configuration word.
    always_comb begin
        cnt_f  = cfg_word[CFG_CNT_LSB +: FCNT_W];
        size_f = cfg_word[CFG_SIZE_LSB +: SIZE_W];
        span   = PROD_W'(cnt_f) * PROD_W'(size_f);
        legal  = (cnt_f != '0) && (cnt_f <= FCNT_W'(MAX_FRAMES)) &&
                 (size_f != '0) && (span <= PROD_W'(SPAD_WORDS)) &&
                 ((cfg_word & ~FIELD_MASK) == '0);
    end

    assign cfg_load = cfg_we && legal;

    // Holds the active configuration, default geometry after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_frames <= FCNT_W'(DEF_FRAMES);
            frame_size <= SIZE_W'(DEF_SIZE);
        end else if (cfg_load) begin
            num_frames <= cnt_f;
            frame_size <= size_f;
        end
    end

    AST_CFG_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (PROD_W'(num_frames) * PROD_W'(frame_size)) <= PROD_W'(SPAD_WORDS)); // R3
endmodule

// File: rtl/spad_frame_locator.sv
`timescale 1ns/1ps
// Maps a word offset to the frame that holds it by comparing the offset with
// each frame's base (index times size); no divider is needed.
// Assumes the configured frames fit in the scratchpad.
module spad_frame_locator #(
    parameter int MAX_FRAMES = 8,
    parameter int OFF_W      = 10,
    parameter int FCNT_W     = 4,
    parameter int SIZE_W     = 11,
    localparam int IDX_W     = $clog2(MAX_FRAMES),
    localparam int PROD_W    = FCNT_W + SIZE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  offset,
    input  logic [FCNT_W-1:0] num_frames,
    input  logic [SIZE_W-1:0] frame_size,
    output logic [IDX_W-1:0]  frame_idx,
    output logic              in_range
);
    logic [MAX_FRAMES-1:0] hit;
    logic [PROD_W-1:0]     off_ext;
    logic [PROD_W-1:0]     size_ext;

    assign off_ext  = PROD_W'(offset);
    assign size_ext = PROD_W'(frame_size);

    for (genvar g = 0; g < MAX_FRAMES; g++) begin : g_win
        logic [PROD_W-1:0] base;
        assign base   = PROD_W'(g) * size_ext;
        assign hit[g] = (FCNT_W'(g) < num_frames) &&
                        (off_ext >= base) && (off_ext < base + size_ext);
    end

    // Encodes the single matching window into a frame index.
    always_comb begin
        frame_idx = '0;
        for (int i = 0; i < MAX_FRAMES; i++) begin
            if (hit[i]) frame_idx = IDX_W'(i);
        end
    end

    assign in_range = |hit;

    AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R4
endmodule

// File: rtl/spad_frame_counters.sv
`timescale 1ns/1ps
// One arrival counter per frame plus the derived free flags. A release clear
// and an arrival to the same frame in one cycle leave a count of one.
// Assumes the caller only increments frames that are not full.
module spad_frame_counters #(
    parameter int MAX_FRAMES = 8,
    parameter int FCNT_W     = 4,
    parameter int SIZE_W     = 11,
    localparam int IDX_W     = $clog2(MAX_FRAMES)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clr_all,
    input  logic                               rel_clr,
    input  logic [IDX_W-1:0]                   rel_idx,
    input  logic                               inc_en,
    input  logic [IDX_W-1:0]                   inc_idx,
    input  logic [FCNT_W-1:0]                  num_frames,
    input  logic [SIZE_W-1:0]                  frame_size,
    output logic [MAX_FRAMES-1:0][SIZE_W-1:0]  cnt,
    output logic [MAX_FRAMES-1:0]              free
);
    for (genvar g = 0; g < MAX_FRAMES; g++) begin : g_frame
        logic [SIZE_W-1:0] c_q;
        logic              bump;
        assign bump = inc_en && (inc_idx == IDX_W'(g));

        // Counts arrivals into this frame; cleared by config or release.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                c_q <= '0;
            end else if (rel_clr && (rel_idx == IDX_W'(g))) begin
                c_q <= bump ? SIZE_W'(1) : '0;
            end else if (bump) begin
                c_q <= c_q + SIZE_W'(1);
            end
        end

        assign cnt[g]  = c_q;
        assign free[g] = (FCNT_W'(g) < num_frames) && (c_q < frame_size);

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            c_q <= frame_size); // R9
    end
endmodule

// File: rtl/spad_frame_tracker.sv
`timescale 1ns/1ps
// Top of the scratchpad frame readiness tracker: circular frames, one counter
// each, a one-cycle release commit, and a start stall that waits on both the
// arrival count and any release in flight.
// Assumes rel_words and start_words refer to the head frame.
module spad_frame_tracker
    import spad_frame_pkg::*;
#(
    parameter int MAX_FRAMES = 8,
    parameter int SPAD_WORDS = 1024,
    parameter int DEF_FRAMES = 4,
    parameter int DEF_SIZE   = 16,
    localparam int FCNT_W    = $clog2(MAX_FRAMES + 1),
    localparam int SIZE_W    = $clog2(SPAD_WORDS + 1),
    localparam int OFF_W     = $clog2(SPAD_WORDS),
    localparam int IDX_W     = $clog2(MAX_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_W-1:0]      cfg_word,
    input  logic                  arr_valid,
    input  logic [OFF_W-1:0]      arr_offset,
    input  logic                  start_req,
    input  logic [SIZE_W-1:0]     start_words,
    input  logic                  rel_req,
    input  logic [SIZE_W-1:0]     rel_words,
    output logic                  stall,
    output logic [MAX_FRAMES-1:0] frame_free,
    output logic                  arr_overflow,
    output logic [IDX_W-1:0]      head_idx
);
    logic                              cfg_load;
    logic [FCNT_W-1:0]                 num_frames;
    logic [SIZE_W-1:0]                 frame_size;
    logic [IDX_W-1:0]                  loc_idx;
    logic                              loc_in;
    logic [MAX_FRAMES-1:0][SIZE_W-1:0] cnt;
    logic                              rel_pend;
    logic [SIZE_W-1:0]                 rel_amt;
    logic [SIZE_W-1:0]                 rel_acc;
    logic [SIZE_W:0]                   rel_sum;
    logic                              commit;
    logic                              tgt_full;
    logic                              tgt_clearing;
    logic                              inc_en;
    logic [SIZE_W-1:0]                 head_cnt;

    spad_frame_cfg #(
        .MAX_FRAMES(MAX_FRAMES), .SPAD_WORDS(SPAD_WORDS),
        .DEF_FRAMES(DEF_FRAMES), .DEF_SIZE(DEF_SIZE)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .cfg_load(cfg_load), .num_frames(num_frames), .frame_size(frame_size)
    );

    spad_frame_locator #(
        .MAX_FRAMES(MAX_FRAMES), .OFF_W(OFF_W), .FCNT_W(FCNT_W), .SIZE_W(SIZE_W)
    ) u_loc (
        .clk(clk), .rst_n(rst_n), .offset(arr_offset), .num_frames(num_frames),
        .frame_size(frame_size), .frame_idx(loc_idx), .in_range(loc_in)
    );

    // Release commit condition: accumulated words reach the frame size.
    always_comb begin
        rel_sum = {1'b0, rel_acc} + {1'b0, rel_amt};
        commit  = rel_pend && (rel_sum >= {1'b0, frame_size});
    end

    // Arrival acceptance: the target must be in range and not full, unless it is being cleared now.
    always_comb begin
        tgt_full     = (cnt[loc_idx] >= frame_size);
        tgt_clearing = commit && (head_idx == loc_idx);
        inc_en       = arr_valid && !cfg_load && loc_in && (!tgt_full || tgt_clearing);
    end

    spad_frame_counters #(
        .MAX_FRAMES(MAX_FRAMES), .FCNT_W(FCNT_W), .SIZE_W(SIZE_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_all(cfg_load),
        .rel_clr(commit), .rel_idx(head_idx),
        .inc_en(inc_en), .inc_idx(loc_idx),
        .num_frames(num_frames), .frame_size(frame_size),
        .cnt(cnt), .free(frame_free)
    );

    // Release pipeline, accumulator and circular head pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_load) begin
            rel_pend <= 1'b0;
            rel_amt  <= '0;
            rel_acc  <= '0;
            head_idx <= '0;
        end else begin
            rel_pend <= rel_req;
            rel_amt  <= rel_words;
            if (commit) begin
                rel_acc  <= '0;
                head_idx <= (FCNT_W'(head_idx) + FCNT_W'(1) >= num_frames) ?
                            '0 : head_idx + IDX_W'(1);
            end else if (rel_pend) begin
                rel_acc  <= rel_sum[SIZE_W-1:0];
            end
        end
    end

    // Overflow flag: a refused arrival, reported one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) arr_overflow <= 1'b0;
        else        arr_overflow <= arr_valid && !cfg_load && !inc_en;
    end

    // Start stall: waits for arrivals in the head frame and for releases in flight.
    always_comb begin
        head_cnt = cnt[head_idx];
        stall    = start_req && (rel_req || rel_pend || (head_cnt < start_words));
    end

    AST_HEAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        FCNT_W'(head_idx) < num_frames); // R6
    AST_COMMIT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !cfg_load && (num_frames > FCNT_W'(1)) |=> head_idx != $past(head_idx)); // R6
    AST_CFG_CLEARS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> head_idx == '0); // R2
    AST_RELEASE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        start_req && $past(rel_req) && !$past(cfg_load) |-> stall); // R7
    AST_OVF_FOLLOWS_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        arr_overflow |-> $past(arr_valid)); // R9
    AST_FREE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_free >> num_frames) == '0); // R8
endmodule

// File: tb/spad_frame_tracker_test.sv
`timescale 1ns/1ps
module spad_frame_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        arr_valid = 1'b0;
    logic [9:0]  arr_offset = '0;
    logic        start_req = 1'b0;
    logic [10:0] start_words = '0;
    logic        rel_req = 1'b0;
    logic [10:0] rel_words = '0;
    logic        stall;
    logic [7:0]  frame_free;
    logic        arr_overflow;
    logic [2:0]  head_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spad_frame_tracker uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .arr_valid(arr_valid), .arr_offset(arr_offset),
        .start_req(start_req), .start_words(start_words),
        .rel_req(rel_req), .rel_words(rel_words),
        .stall(stall), .frame_free(frame_free),
        .arr_overflow(arr_overflow), .head_idx(head_idx)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic arrive(input int off);
        arr_valid  = 1'b1;
        arr_offset = 10'(off);
        @(negedge clk);
        arr_valid  = 1'b0;
    endtask

    task automatic release_words(input int n);
        rel_req   = 1'b1;
        rel_words = 11'(n);
        @(negedge clk);
        rel_req   = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_cfg(input int cnt, input int size, input logic [31:0] extra);
        cfg_we   = 1'b1;
        cfg_word = (32'(size) << 16) | 32'(cnt) | extra;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 free", int'(frame_free), 'h0F);
        chk("R1 head", int'(head_idx), 0);
        chk("R1 stall", int'(stall), 0);
        chk("R1 overflow", int'(arr_overflow), 0);
        start_req = 1'b1; start_words = 11'd0; #1;
        chk("R10 zero-word start", int'(stall), 0);
        start_words = 11'd1; #1;
        chk("R5 empty frame stalls", int'(stall), 1);
        start_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_fill;
        for (int i = 0; i < 15; i++) arrive(i);
        start_req = 1'b1; start_words = 11'd16; #1;
        chk("R5 15 of 16 stalls", int'(stall), 1);
        arr_valid = 1'b1; arr_offset = 10'd15; #1;
        chk("R5 stall held in arrival cycle", int'(stall), 1);
        @(negedge clk); arr_valid = 1'b0; #1;
        chk("R5 stall falls after last word", int'(stall), 0);
        chk("R8 full frame not free", int'(frame_free), 'h0E);
        start_words = 11'd17; #1;
        chk("R5 more than arrived stalls", int'(stall), 1);
        start_req = 1'b0;
        arrive(20);
        chk("R4 offset 20 lands in frame 1", int'(frame_free), 'h0E);
    endtask

    task automatic t_overflow;
        arrive(3);
        chk("R9 overflow into full frame", int'(arr_overflow), 1);
        @(negedge clk);
        chk("R9 overflow one cycle", int'(arr_overflow), 0);
        start_req = 1'b1; start_words = 11'd16; #1;
        chk("R9 count kept at size", int'(stall), 0);
        start_req = 1'b0;
        arrive(64);
        chk("R4 offset past region overflows", int'(arr_overflow), 1);
        @(negedge clk);
    endtask

    task automatic t_release;
        start_req = 1'b1; start_words = 11'd0;
        rel_req = 1'b1; rel_words = 11'd8; #1;
        chk("R7 stall in release cycle", int'(stall), 1);
        @(negedge clk); rel_req = 1'b0; #1;
        chk("R7 stall while pending", int'(stall), 1);
        @(negedge clk);
        chk("R6 partial release keeps head", int'(head_idx), 0);
        chk("R10 start free after commit", int'(stall), 0);
        start_req = 1'b0;
        release_words(8);
        chk("R6 head advances", int'(head_idx), 1);
        chk("R6 frame 0 cleared and free", int'(frame_free), 'h0F);
    endtask

    task automatic t_config;
        write_cfg(3, 2, 32'h0);
        chk("R2 three frames free", int'(frame_free), 'h07);
        chk("R2 head cleared", int'(head_idx), 0);
        arrive(4); arrive(5);
        chk("R4 offsets 4,5 fill frame 2", int'(frame_free), 'h03);
        arrive(6);
        chk("R4 offset 6 out of region", int'(arr_overflow), 1);
        write_cfg(5, 256, 32'h0);
        chk("R3 oversize span ignored", int'(frame_free), 'h03);
        write_cfg(9, 1, 32'h0);
        chk("R3 count 9 ignored", int'(frame_free), 'h03);
        write_cfg(0, 4, 32'h0);
        chk("R3 count 0 ignored", int'(frame_free), 'h03);
        write_cfg(2, 0, 32'h0);
        chk("R3 size 0 ignored", int'(frame_free), 'h03);
        write_cfg(3, 2, 32'h8000_0000);
        chk("R3 reserved bit ignored", int'(frame_free), 'h03);
        write_cfg(8, 128, 32'h0);
        chk("R2 full 1024-word span accepted", int'(frame_free), 'hFF);
        write_cfg(3, 2, 32'h0);
        chk("R2 reload clears counters", int'(frame_free), 'h07);
    endtask

    task automatic t_wrap;
        release_words(2);
        chk("R6 head 1", int'(head_idx), 1);
        release_words(2);
        chk("R6 head 2", int'(head_idx), 2);
        release_words(2);
        chk("R6 head wraps to 0", int'(head_idx), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_overflow();
        t_release();
        t_config();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule